// File: doc/BRIEF.md
# Addressable Tap Shift Register

This block is a serial-in delay line built from 16-stage segments, whose output tap is picked at run time. Each sample presented on `din` enters the first stage on a rising clock edge that has `ce` high. The `depth` input selects which stage drives `dout`, so the delay can be retuned on any cycle without flushing the line. It is meant for balancing pipeline branches of unequal latency, and for programmable pipeline delays.

Several segments are chained by a parameter. The low four bits of `depth` pick a stage inside a segment, and the upper bits pick the segment. A separate output always presents the final stage of the whole chain, whatever `depth` holds, so that a further instance can be fed from it for still longer delays. A parameter can add a trailing output flip-flop, which gives one extra cycle of delay and shortens the path from the tap multiplexer. Only that trailing flop is reset. The storage stages are never reset.

Top module: `tapsr_top`

## Requirements
- R1: On every rising clock edge with `ce` high, stage 0 takes `din` and every stage k>0 takes the old value of stage k-1. With `depth`=0 and no output flop, `dout` shows the `din` value accepted at the most recent such edge.
- R2: On a rising edge with `ce` low, every stage keeps its value, so `cascade_out` is unchanged and `dout` is unchanged while `depth` is held.
- R3: With no output flop, `dout` equals the sample accepted `depth`+1 accepted edges ago (stage index `depth`, where stage 0 is the newest). This gives a delay of 1 to 16×SEG_COUNT accepted samples.
- R4: `dout` follows a change of `depth` combinationally within the same cycle, with no clock edge needed.
- R5: Bits [ADDR_W-1:4] of `depth` select the segment, and bits [3:0] select the stage within it. With the default two segments, values 16 to 31 read from the second segment.
- R6: `cascade_out` always presents the last stage of the last segment, which is the sample accepted 16×SEG_COUNT accepted edges ago, independent of `depth`.
- R7: The stages have no reset. Asserting `rst_n` leaves the stored samples intact, so after a reset pulse taken with `ce` low, `dout` and `cascade_out` show the same history as before.
- R8: With OUT_REG=1, `dout` is a flop that loads the selected tap on each `ce`-high edge and otherwise holds. With `depth` held steady, this gives the sample at stage `depth`+1. The flop clears to 0 while `rst_n` is low, and it resumes loading on the third rising edge after `rst_n` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, used only by the optional output flop |
| ce | input | 1 | Shift enable |
| din | input | 1 | Serial data in |
| depth | input | ADDR_W (4+log2 SEG_COUNT) | Tap address: upper bits select the segment, low 4 bits select the stage |
| dout | output | 1 | Selected tap, or its registered copy when OUT_REG=1 |
| cascade_out | output | 1 | Final stage of the chain, for feeding a following delay line |

## Verification
The properties assume that `ce`, `din` and `depth` are driven to known levels and change only between clock edges. They also assume that `depth` addresses an existing segment, because SEG_COUNT is a power of two. The registered-output property also assumes that `depth` is steady across an enabled edge whenever the extra cycle is measured. The stimulus changes inputs only on falling edges and keeps `depth` within 0 to 31 for the default two segments. It changes `depth` in the middle of a low clock phase only in the test of the combinational tap. Outputs are compared against a history word of accepted samples only after more than 32 samples have entered, so the unreset stages never feed a comparison.

// File: rtl/tapsr_pkg.sv
package tapsr_pkg;
  // Stages in one segment and the tap-select width that addresses them
  localparam int SEG_LEN = 16;
  localparam int SEL_W   = $clog2(SEG_LEN);
endpackage

// File: rtl/tapsr_rst_sync.sv
module tapsr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/tapsr_segment.sv
module tapsr_segment
  import tapsr_pkg::*;
(
  input  logic             clk,
  input  logic             ce,
  input  logic             din,
  input  logic [SEL_W-1:0] sel,
  output logic             tap,
  output logic             last
);
  // Storage stages carry no reset by design
  logic [SEG_LEN-1:0] stg_q;
  logic [SEG_LEN-1:0] stg_d;

  always_comb begin
    if (ce) stg_d = {stg_q[SEG_LEN-2:0], din};
    else    stg_d = stg_q;
  end

  always_ff @(posedge clk) begin
    stg_q <= stg_d;
  end

  assign tap  = stg_q[sel];
  assign last = stg_q[SEG_LEN-1];
endmodule

// File: rtl/tapsr_chain.sv
module tapsr_chain
  import tapsr_pkg::*;
#(
  parameter int SEG_COUNT = 2
) (
  input  logic                 clk,
  input  logic                 ce,
  input  logic                 din,
  input  logic [SEL_W-1:0]     sel,
  output logic [SEG_COUNT-1:0] taps,
  output logic                 cascade_out
);
  logic [SEG_COUNT:0] link;

  assign link[0] = din;

  for (genvar g = 0; g < SEG_COUNT; g++) begin : g_seg
    tapsr_segment u_seg (
      .clk  (clk),
      .ce   (ce),
      .din  (link[g]),
      .sel  (sel),
      .tap  (taps[g]),
      .last (link[g+1])
    );
  end

  assign cascade_out = link[SEG_COUNT];
endmodule

// File: rtl/tapsr_segsel.sv
module tapsr_segsel
  import tapsr_pkg::*;
#(
  parameter int SEG_COUNT = 2,
  localparam int ADDR_W   = SEL_W + $clog2(SEG_COUNT)
) (
  input  logic [SEG_COUNT-1:0] taps,
  input  logic [ADDR_W-1:0]    depth,
  output logic                 tap
);
  if (SEG_COUNT == 1) begin : g_single
    logic unused_depth;
    assign unused_depth = ^depth;
    assign tap = taps[0];
  end else begin : g_multi
    logic [ADDR_W-SEL_W-1:0] seg_idx;
    logic unused_low;
    assign seg_idx    = depth[ADDR_W-1:SEL_W];
    assign unused_low = ^depth[SEL_W-1:0];
    assign tap        = taps[seg_idx];
  end
endmodule

// File: rtl/tapsr_outstage.sv
module tapsr_outstage #(
  parameter bit OUT_REG = 1'b0
) (
  input  logic clk,
  input  logic rst_sync_n,
  input  logic ce,
  input  logic tap,
  output logic dout
);
  if (OUT_REG) begin : g_reg
    logic out_q;
    logic out_d;

    always_comb begin
      if (ce) out_d = tap;
      else    out_d = out_q;
    end

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) out_q <= 1'b0;
      else             out_q <= out_d;
    end

    assign dout = out_q;
  end else begin : g_comb
    logic unused_ctl;
    assign unused_ctl = clk ^ rst_sync_n ^ ce;
    assign dout = tap;
  end
endmodule

// File: rtl/tapsr_top.sv
module tapsr_top
  import tapsr_pkg::*;
#(
  parameter int  SEG_COUNT = 2,
  parameter bit  OUT_REG   = 1'b0,
  localparam int ADDR_W    = SEL_W + $clog2(SEG_COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              din,
  input  logic [ADDR_W-1:0] depth,
  output logic              dout,
  output logic              cascade_out
);
  logic [SEG_COUNT-1:0] taps;
  logic                 tap_sel;
  logic                 rst_sync_n;

  tapsr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tapsr_chain #(.SEG_COUNT(SEG_COUNT)) u_chain (
    .clk         (clk),
    .ce          (ce),
    .din         (din),
    .sel         (depth[SEL_W-1:0]),
    .taps        (taps),
    .cascade_out (cascade_out)
  );

  tapsr_segsel #(.SEG_COUNT(SEG_COUNT)) u_sel (
    .taps  (taps),
    .depth (depth),
    .tap   (tap_sel)
  );

  tapsr_outstage #(.OUT_REG(OUT_REG)) u_out (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .ce         (ce),
    .tap        (tap_sel),
    .dout       (dout)
  );
endmodule

// File: rtl/tapsr_chk.sv
module tapsr_chk
  import tapsr_pkg::*;
#(
  parameter int  SEG_COUNT = 2,
  parameter bit  OUT_REG   = 1'b0,
  localparam int ADDR_W    = SEL_W + $clog2(SEG_COUNT),
  localparam int MAX_TAP   = SEG_LEN * SEG_COUNT - 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce,
  input logic              din,
  input logic [ADDR_W-1:0] depth,
  input logic              dout,
  input logic              cascade_out
);
  // R2
  hold_cascade_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(cascade_out));

  if (OUT_REG) begin : g_reg_chk
    // R8
    hold_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ce |=> $stable(dout));
  end else begin : g_comb_chk
    // R2
    hold_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ce |=> (!$stable(depth) || $stable(dout)));
    // R1
    first_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && depth == '0) |=> (depth != '0 || dout == $past(din)));
    // R6
    cascade_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (depth == ADDR_W'(MAX_TAP)) |-> (dout == cascade_out));
  end
endmodule

bind tapsr_top tapsr_chk #(.SEG_COUNT(SEG_COUNT), .OUT_REG(OUT_REG)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ce          (ce),
  .din         (din),
  .depth       (depth),
  .dout        (dout),
  .cascade_out (cascade_out)
);

// File: tb/sim_tapsr_top.sv
module sim_tapsr_top;
  logic       clk;
  logic       rst_n;
  logic       ce;
  logic       din;
  logic [4:0] depth;
  logic       dout0, casc0, dout1, casc1;

  int checks;
  int failures;
  logic [63:0] hist;   // bit 0 = newest accepted sample
  logic        exp_r;  // expected registered output

  tapsr_top u0 (.clk(clk), .rst_n(rst_n), .ce(ce), .din(din), .depth(depth),
                .dout(dout0), .cascade_out(casc0));
  tapsr_top #(.OUT_REG(1'b1)) u1 (.clk(clk), .rst_n(rst_n), .ce(ce), .din(din),
                .depth(depth), .dout(dout1), .cascade_out(casc1));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {din, ce, depth[4:0]}
  localparam logic [6:0] VEC [0:19] = '{
    7'b1_1_00000, 7'b0_1_00000, 7'b1_1_00101, 7'b1_1_01111,
    7'b0_1_10000, 7'b1_1_11111, 7'b0_0_00011, 7'b1_0_00011,
    7'b1_1_10100, 7'b0_1_01000, 7'b0_1_11110, 7'b1_1_00001,
    7'b1_0_10001, 7'b0_0_10001, 7'b1_1_11000, 7'b0_1_00111,
    7'b1_1_10011, 7'b0_1_00000, 7'b1_1_01110, 7'b0_1_11111
  };

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b time=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic d, input logic c, input logic [4:0] dp,
                      input bit do_chk, input string tag);
    @(negedge clk);
    din = d; ce = c; depth = dp;
    @(posedge clk);
    if (c) begin
      exp_r = hist[dp];
      hist  = {hist[62:0], d};
    end
    #2;
    if (do_chk) begin
      if (dp == 5'd0 && c) check("R1 newest sample at tap 0", dout0, d);
      if (dp >= 5'd16) check({tag, " R5 second segment tap"}, dout0, hist[dp]);
      else             check({tag, " R3 tap value"}, dout0, hist[dp]);
      check({tag, " R6 cascade last stage"}, casc0, hist[31]);
      check({tag, " R8 registered tap"}, dout1, exp_r);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0; hist = '0; exp_r = 1'b0;
    rst_n = 1'b0; ce = 1'b0; din = 1'b0; depth = '0;
    repeat (3) @(posedge clk);
    #2;
    check("R8 reset state of output flop", dout1, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // Fill the line so no unreset stage is ever compared
    for (int i = 0; i < 40; i++)
      step(((i * 5) % 7) > 2, 1'b1, 5'(i % 32), 1'b0, "fill");

    // Vector table
    for (int i = 0; i < 20; i++)
      step(VEC[i][6], VEC[i][5], VEC[i][4:0], 1'b1, (VEC[i][5] ? "vec" : "vec R2 hold"));

    // R2: enable low for several edges, history must not move
    for (int i = 0; i < 4; i++)
      step(i[0], 1'b0, 5'd9, 1'b1, "R2 hold");

    // R4: change depth with no clock edge in between
    @(negedge clk);
    ce = 1'b0;
    foreach (VEC[i]) begin
      if (i < 6) begin
        depth = VEC[i][4:0] ^ 5'(i * 3);
        #1;
        check("R4 combinational tap follow", dout0, hist[depth]);
      end
    end

    // R7: reset pulse with ce low leaves the stages intact
    @(negedge clk); rst_n = 1'b0; ce = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check("R8 flop cleared by reset", dout1, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    exp_r = 1'b0;
    for (int k = 0; k < 32; k += 5) begin
      @(negedge clk); depth = 5'(k); #1;
      check("R7 stages keep data through reset", dout0, hist[k]);
    end
    check("R7 cascade keeps data through reset", casc0, hist[31]);

    // Post-reset shifting, including both segment ends
    step(1'b1, 1'b1, 5'd15, 1'b1, "post");
    step(1'b0, 1'b1, 5'd16, 1'b1, "post");
    step(1'b1, 1'b1, 5'd31, 1'b1, "post");
    step(1'b1, 1'b1, 5'd0,  1'b1, "post");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule